// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This unit works out the next program counter for a 64-bit integer core. Each cycle it takes one 32-bit instruction word and two source operand values. It handles conditional branches (major opcode 0x63) and the PC-relative jump-and-link instruction (major opcode 0x6F). Every other opcode advances the counter by four.

For a branch, the unit rebuilds the signed offset from its scattered fields and compares the two operands using the comparison that the minor opcode selects. It then picks either the PC-relative target or the sequential address. For a jump, it always takes the target and requests a write of the return address to the destination register. The unit keeps the program counter in a register, which loads the computed next address on every clock edge where the instruction is marked valid. A synchronous reset loads a configurable start address.

Top module: `brnpc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the PC register loads `RESET_VEC`. `pcOut` shows that value from the following cycle.
- R2: An instruction word whose bits [6:0] are neither 0x63 nor 0x6F gives `nextPc = pcOut + 4`, `flowKind = 0`, and `linkEn` low.
- R3: For opcode 0x63, the offset is {iw[31], iw[7], iw[30:25], iw[11:8], 0}, sign-extended from its bit 12. A taken branch gives `nextPc = pcOut + offset`.
- R4: A branch that is not taken gives `nextPc = pcOut + 4`.
- R5: Branch condition by iw[14:12]: 0 means the operands are equal, 1 means they are not equal, 4 means signed less-than, 5 means signed greater-or-equal, 6 means unsigned less-than, 7 means unsigned greater-or-equal.
- R6: Signed conditions treat bit 63 as the sign, so a negative operand is less than any non-negative one. Unsigned conditions treat the same value as large.
- R7: For opcode 0x6F, the offset is {iw[31], iw[19:12], iw[20], iw[30:21], 0}, sign-extended from its bit 20. `nextPc = pcOut + offset` always.
- R8: For opcode 0x6F, `linkIdx = iw[11:7]` and `linkData = pcOut + 4`. `linkEn` is high only when iw[11:7] is nonzero and `instValid` is high.
- R9: Under opcode 0x63, iw[14:12] values 2 and 3 are never taken and give `pcOut + 4`.
- R10: With `instValid` low, the PC register keeps its value at the clock edge and `linkEn` stays low.
- R11: `flowKind` encodes the current word: 0 for sequential, 1 for a branch not taken, 2 for a branch taken, 3 for a jump.
- R12: A negative offset moves the PC backwards. For example, a branch offset of -8 gives `pcOut - 8`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | Current instruction word is valid; enables the PC update and link write |
| instWord | input | 32 | Instruction word |
| srcA | input | XLEN | First comparison operand |
| srcB | input | XLEN | Second comparison operand |
| pcOut | output | XLEN | Current program counter (registered) |
| nextPc | output | XLEN | Computed next program counter |
| linkEn | output | 1 | Return-address write enable |
| linkIdx | output | 5 | Destination register index for the return address |
| linkData | output | XLEN | Return address (pcOut + 4) |
| flowKind | output | 2 | Control-flow class of the current word |

## Verification
The bench builds the unit with the default 64-bit width and a start address of 0x1000. With this start address, both forward and backward offsets produce addresses that can be checked by hand. Operands with bit 63 set make the signed and unsigned comparisons disagree on the same pair. Jump offsets near the ends of the 21-bit range exercise the sign extension from bit 20 across the full 64-bit counter.

// File: rtl/brnpc_pkg.sv
package brnpc_pkg;

  typedef enum logic [1:0] {
    FLOW_SEQ   = 2'd0,
    FLOW_BR_NT = 2'd1,
    FLOW_BR_TK = 2'd2,
    FLOW_JUMP  = 2'd3
  } flow_e;

  // Result of comparing the two operands, produced by the datapath.
  typedef struct packed {
    logic eq;
    logic ltS;
    logic ltU;
  } cmp_flags_t;

  // Strobes sent from control to the datapath.
  typedef struct packed {
    logic takeTarget;
    logic useJump;
    logic linkWr;
  } npc_strobes_t;

  localparam logic [6:0] OPC_BRANCH = 7'h63;
  localparam logic [6:0] OPC_JAL    = 7'h6F;

endpackage

// File: rtl/brnpc_ctrl.sv
module brnpc_ctrl
  import brnpc_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         instValid,
  input  logic [6:0]   opcode,
  input  logic [2:0]   funct3,
  input  logic [4:0]   rdIdx,
  input  cmp_flags_t   flags,
  output npc_strobes_t strobes,
  output flow_e        flowKind
);

  logic isBranch;
  logic isJump;
  logic condHit;

  assign isBranch = (opcode == OPC_BRANCH);
  assign isJump   = (opcode == OPC_JAL);

  always_comb begin
    unique case (funct3)
      3'd0:    condHit = flags.eq;
      3'd1:    condHit = !flags.eq;
      3'd4:    condHit = flags.ltS;
      3'd5:    condHit = !flags.ltS;
      3'd6:    condHit = flags.ltU;
      3'd7:    condHit = !flags.ltU;
      default: condHit = 1'b0;   // 2 and 3: never taken
    endcase
  end

  always_comb begin
    strobes.takeTarget = isJump || (isBranch && condHit);
    strobes.useJump    = isJump;
    strobes.linkWr     = isJump && (rdIdx != 5'd0) && instValid;
    if (isJump)        flowKind = FLOW_JUMP;
    else if (isBranch) flowKind = condHit ? FLOW_BR_TK : FLOW_BR_NT;
    else               flowKind = FLOW_SEQ;
  end

  AST_STROBE_CLASS: assert property (@(posedge clk) disable iff (rst)
    strobes.takeTarget |-> (flowKind == FLOW_JUMP || flowKind == FLOW_BR_TK)); // R11

  AST_RSVD_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (isBranch && (funct3 == 3'd2 || funct3 == 3'd3)) |-> !strobes.takeTarget); // R9

endmodule

// File: rtl/brnpc_datapath.sv
module brnpc_datapath
  import brnpc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  input  logic [31:7]     instHi,
  input  npc_strobes_t    strobes,
  output cmp_flags_t      flags,
  output logic [XLEN-1:0] nextPc,
  output logic [XLEN-1:0] linkData
);

  localparam int BR_W  = 13;
  localparam int JMP_W = 21;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [BR_W-1:0]  brRaw;
  logic [JMP_W-1:0] jmpRaw;
  logic [XLEN-1:0]  brOff;
  logic [XLEN-1:0]  jmpOff;
  logic [XLEN-1:0]  seqPc;
  logic [XLEN-1:0]  tgtPc;

  // Offset fields are gathered back into order; the lowest bit is always zero.
  assign brRaw  = {instHi[31], instHi[7], instHi[30:25], instHi[11:8], 1'b0};
  assign jmpRaw = {instHi[31], instHi[19:12], instHi[20], instHi[30:21], 1'b0};

  assign brOff  = {{(XLEN-BR_W){brRaw[BR_W-1]}}, brRaw};
  assign jmpOff = {{(XLEN-JMP_W){jmpRaw[JMP_W-1]}}, jmpRaw};

  assign flags.eq  = (srcA == srcB);
  assign flags.ltS = ($signed(srcA) < $signed(srcB));
  assign flags.ltU = (srcA < srcB);

  assign seqPc    = pc + STEP;
  assign tgtPc    = pc + (strobes.useJump ? jmpOff : brOff);
  assign nextPc   = strobes.takeTarget ? tgtPc : seqPc;
  assign linkData = seqPc;

endmodule

// File: rtl/brnpc_unit.sv
module brnpc_unit
  import brnpc_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter logic [XLEN-1:0] RESET_VEC = XLEN'(64'h8000_0000)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instValid,
  input  logic [31:0]     instWord,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  output logic [XLEN-1:0] pcOut,
  output logic [XLEN-1:0] nextPc,
  output logic            linkEn,
  output logic [4:0]      linkIdx,
  output logic [XLEN-1:0] linkData,
  output logic [1:0]      flowKind
);

  npc_strobes_t strobes;
  cmp_flags_t   flags;
  flow_e        flowSel;
  logic [XLEN-1:0] pcQ;

  brnpc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .instValid(instValid),
    .opcode   (instWord[6:0]),
    .funct3   (instWord[14:12]),
    .rdIdx    (instWord[11:7]),
    .flags    (flags),
    .strobes  (strobes),
    .flowKind (flowSel)
  );

  brnpc_datapath #(.XLEN(XLEN)) u_dp (
    .pc      (pcQ),
    .srcA    (srcA),
    .srcB    (srcB),
    .instHi  (instWord[31:7]),
    .strobes (strobes),
    .flags   (flags),
    .nextPc  (nextPc),
    .linkData(linkData)
  );

  always_ff @(posedge clk) begin
    if (rst)            pcQ <= RESET_VEC;
    else if (instValid) pcQ <= nextPc;
  end

  assign pcOut    = pcQ;
  assign linkEn   = strobes.linkWr;
  assign linkIdx  = instWord[11:7];
  assign flowKind = flowSel;

  AST_RESET_VECTOR: assert property (@(posedge clk)
    rst |=> (pcOut == RESET_VEC)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !instValid |=> $stable(pcOut)); // R10

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (instValid && (flowKind == FLOW_SEQ || flowKind == FLOW_BR_NT))
      |=> (pcOut == $past(pcOut) + XLEN'(4))); // R4

  AST_LINK_ONLY_JUMP: assert property (@(posedge clk) disable iff (rst)
    linkEn |-> (flowKind == FLOW_JUMP && linkIdx != 5'd0 && instValid)); // R8

endmodule

// File: tb/sim_brnpc_unit.sv
module sim_brnpc_unit;

  localparam logic [63:0] RVEC = 64'h1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instValid = 1'b0;
  logic [31:0] instWord = 32'h0000_0013;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic [63:0] pcOut, nextPc, linkData;
  logic        linkEn;
  logic [4:0]  linkIdx;
  logic [1:0]  flowKind;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;
  logic [63:0] expPc;

  always #2 clk = ~clk;   // 250 MHz

  brnpc_unit #(.XLEN(64), .RESET_VEC(RVEC)) u0 (
    .clk(clk), .rst(rst), .instValid(instValid), .instWord(instWord),
    .srcA(srcA), .srcB(srcB), .pcOut(pcOut), .nextPc(nextPc),
    .linkEn(linkEn), .linkIdx(linkIdx), .linkData(linkData), .flowKind(flowKind)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] encB(input int off, input logic [2:0] f3);
    logic [12:0] o = off[12:0];
    return {o[12], o[10:5], 5'd2, 5'd1, f3, o[4:1], o[11], 7'h63};
  endfunction

  function automatic logic [31:0] encJ(input int off, input logic [4:0] rd);
    logic [20:0] o = off[20:0];
    return {o[20], o[10:1], o[11], o[19:12], rd, 7'h6F};
  endfunction

  // Drive one word, compare the combinational outputs against the model,
  // then advance the model's PC at the clock edge.
  task automatic step(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                      input bit v, input longint off, input string tag);
    logic [63:0] seq, nxt;
    logic        le, take;
    logic [1:0]  fk;
    @(negedge clk);
    instWord = w; srcA = a; srcB = b; instValid = v;
    #1;
    seq = expPc + 64'd4; nxt = seq; le = 0; fk = 2'd0; take = 0;
    if (w[6:0] == 7'h63) begin
      case (w[14:12])
        3'd0: take = (a == b);
        3'd1: take = (a != b);
        3'd4: take = ($signed(a) < $signed(b));
        3'd5: take = ($signed(a) >= $signed(b));
        3'd6: take = (a < b);
        3'd7: take = (a >= b);
        default: take = 0;
      endcase
      fk  = take ? 2'd2 : 2'd1;
      nxt = take ? expPc + 64'(off) : seq;
    end else if (w[6:0] == 7'h6F) begin
      fk  = 2'd3;
      nxt = expPc + 64'(off);
      le  = (w[11:7] != 5'd0);
    end
    le = le && v;
    chk(tag, "pcOut",    pcOut,    expPc);
    chk(tag, "nextPc",   nextPc,   nxt);
    chk(tag, "flowKind", 64'(flowKind), 64'(fk));   // R11
    chk(tag, "linkEn",   64'(linkEn),   64'(le));
    if (w[6:0] == 7'h6F) begin
      chk(tag, "linkIdx",  64'(linkIdx), 64'(w[11:7]));
      chk(tag, "linkData", linkData, seq);
    end
    @(posedge clk);
    if (v) expPc = nxt;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    expPc = RVEC;
    #1 chk("R1", "reset pc", pcOut, RVEC);

    // R2: unrelated opcodes step by four
    step(32'h0630_0293, 64'd0, 64'd0, 1, 0, "R2");
    step(32'h0000_0033, 64'd5, 64'd5, 1, 0, "R2");

    // R3/R5: equal / not equal
    step(encB(12, 3'd0), 64'd7, 64'd7, 1, 12, "R3 beq taken");
    step(encB(12, 3'd0), 64'd7, 64'd8, 1, 12, "R4 beq not taken");
    step(encB(256, 3'd1), 64'd1, 64'd2, 1, 256, "R5 bne taken");
    step(encB(256, 3'd1), 64'd3, 64'd3, 1, 256, "R5 bne not taken");

    // R6: signed vs unsigned with bit 63 set
    step(encB(16, 3'd4), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1, 16, "R6 blt neg<pos");
    step(encB(16, 3'd6), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1, 16, "R6 bltu big");
    step(encB(20, 3'd5), 64'd0, 64'h8000_0000_0000_0000, 1, 20, "R6 bge");
    step(encB(20, 3'd7), 64'd0, 64'h8000_0000_0000_0000, 1, 20, "R6 bgeu");
    step(encB(4094, 3'd5), 64'd9, 64'd9, 1, 4094, "R3 max fwd offset");

    // R12: backward branches
    step(encB(-8, 3'd0), 64'd0, 64'd0, 1, -8, "R12 back -8");
    step(encB(-4096, 3'd7), 64'd5, 64'd5, 1, -4096, "R12 back min");

    // R9: reserved conditions never taken
    step(encB(40, 3'd2), 64'd1, 64'd1, 1, 40, "R9 f3=2");
    step(encB(40, 3'd3), 64'd1, 64'd2, 1, 40, "R9 f3=3");

    // R7/R8: jumps
    step(encJ(64, 5'd1), 64'd0, 64'd0, 1, 64, "R8 jal link ra");
    step(encJ(2048, 5'd0), 64'd0, 64'd0, 1, 2048, "R8 jal rd=0");
    step(encJ(1048574, 5'd31), 64'd0, 64'd0, 1, 1048574, "R7 jal max");
    step(encJ(-1048576, 5'd5), 64'd0, 64'd0, 1, -1048576, "R7 jal min");
    step(encJ(-12, 5'd3), 64'd0, 64'd0, 1, -12, "R12 jal back");

    // R10: invalid words hold the PC and suppress the link
    step(encJ(64, 5'd1), 64'd0, 64'd0, 0, 64, "R10 idle jal");
    step(encB(12, 3'd0), 64'd7, 64'd7, 0, 12, "R10 idle beq");
    step(32'h0000_0013, 64'd0, 64'd0, 1, 0, "R10 resume");

    // R1: reset in mid-run
    @(negedge clk); rst = 1'b1; instValid = 1'b1;
    @(posedge clk);
    @(negedge clk); rst = 1'b0; instValid = 1'b0;
    expPc = RVEC;
    #1 chk("R1", "mid-run reset pc", pcOut, RVEC);
    step(encB(8, 3'd1), 64'd1, 64'd0, 1, 8, "R1 after reset");
    step(32'h0000_0013, 64'd0, 64'd0, 1, 0, "R2 final");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule